// File: doc/BRIEF.md
# PCI Interrupt Routing Autodetector

This block decides how the interrupt pins of the PCI slots reach the four system interrupt lines. Two routing schemes exist. The first passes pin n of every slot straight to output n. The second rotates pins by slot. Older guest software assumes the pass-through scheme, so the block watches configuration writes to learn which scheme the guest expects. The first write to a slot's interrupt-line register that separates the two schemes fixes the mode. The mode then holds until reset.

A strap chooses between two board variants, and each variant rotates by a different amount. On the second variant detection is switched off, so a write never changes the mode. A reset-time input lets integration logic preload the mode when the guest is already known to be good or bad. The interrupt outputs are combinational in the pin levels and the current mode. The mode itself is a register that updates on the clock edge at which a write is seen.

Top module: `irq_route_detect`

## Requirements
- R1: While rst_ni is low, mode_o takes its value from boot_mode_i: 0 means assume-ok, 1 means broken, 2 means force-ok, and the value 3 loads assume-ok. mode_o only ever shows the codes 0, 1 or 2.
- R2: Once mode_o is broken (1) or force-ok (2), it keeps that value until the next reset, whatever writes arrive.
- R3: A write is classified only when all of these hold: cfg_we_i is high, cfg_addr_i[7:0] is 0x3C, mode_o is assume-ok and alt_board_i is 0. Any other write leaves the mode unchanged.
- R4: The slot is cfg_addr_i[15:11], and s below is that slot modulo 4, which is cfg_addr_i[12:11]. A classified write of the value 27 leaves assume-ok in place when s is 2. For any other s it sets broken.
- R5: A classified write of the value 27+s, or of the value 91+s, sets broken.
- R6: A classified write of any value not named in R4 or R5 sets force-ok.
- R7: In broken mode, pin p of every slot drives irq_o[p]. Pin p of slot k is pin_lvl_i[4*k+p].
- R8: In any mode other than broken with alt_board_i at 0, pin p of slot k drives irq_o[(k+p+2) mod 4].
- R9: In any mode other than broken with alt_board_i at 1, pin p of slot k drives irq_o[(k+p+3) mod 4].
- R10: Each output is the OR of all pin levels routed to it. When every pin is low, every output is low.
- R11: The mode changes at the clock edge that samples the classified write, and not before. irq_o follows pin and mode changes with no added register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr_i | input | 24 | Configuration address; [15:8] device/function, [7:0] register offset |
| cfg_wdata_i | input | 8 | Byte written to the addressed register |
| alt_board_i | input | 1 | Board variant strap; 1 selects the second variant and turns detection off |
| boot_mode_i | input | 2 | Mode loaded while reset is asserted |
| pin_lvl_i | input | 32 | Interrupt pin levels, four per slot, with slot k at bits [4k+3:4k] |
| mode_o | output | 2 | Current mode: 0 assume-ok, 1 broken, 2 force-ok |
| irq_o | output | 4 | System interrupt lines |

## Verification
On every cycle the assertions check four things: the mode code is legal, a settled mode stays fixed, the mode holds while the second board variant is strapped, and an unrecognised line value moves assume-ok to force-ok. They also check that no output is raised without a pin behind it, and that no more outputs are high than there are active pins. Only the bench scenarios can show that each pin reaches the correct output in each mode and variant. The same holds for the slot-2 exception for the value 27, the high-offset values, writes that are off-offset, disabled or arrive while the second variant is strapped, and the exact cycle at which the mode moves.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  typedef enum logic [1:0] {
    MODE_ASSUME = 2'd0,
    MODE_BROKEN = 2'd1,
    MODE_FORCE  = 2'd2
  } route_mode_e;

  localparam int unsigned PINS_PER_SLOT = 4;
  localparam int unsigned NUM_LINES     = 4;
endpackage

// File: rtl/irq_write_classifier.sv
module irq_write_classifier
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter logic [7:0]  LINE_OFS = 8'h3C,
  parameter int unsigned BASE_IRQ = 27,
  parameter int unsigned HIGH_OFS = 64
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              alt_board_i,
  output logic              hit_o,
  output route_mode_e       verdict_o
);
  // slot is devfn[7:3] = addr[15:11]; modulo 4 keeps addr[12:11]
  logic [1:0] slot_mod;
  logic [7:0] lo_val, hi_val;

  assign slot_mod = addr_i[12:11];
  assign lo_val   = 8'(BASE_IRQ) + {6'b0, slot_mod};
  assign hi_val   = lo_val + 8'(HIGH_OFS);
  assign hit_o    = we_i && (addr_i[7:0] == LINE_OFS) && !alt_board_i;

  always_comb begin
    if (data_i == 8'(BASE_IRQ))
      verdict_o = (slot_mod == 2'd2) ? MODE_ASSUME : MODE_BROKEN;
    else if (data_i == lo_val || data_i == hi_val)
      verdict_o = MODE_BROKEN;
    else
      verdict_o = MODE_FORCE;
  end
endmodule

// File: rtl/irq_mode_fsm.sv
module irq_mode_fsm
  import irq_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  boot_mode_i,
  input  logic        hit_i,
  input  route_mode_e verdict_i,
  output route_mode_e mode_o
);
  route_mode_e mode_q, boot_mode;

  assign boot_mode = (boot_mode_i == 2'd3) ? MODE_ASSUME : route_mode_e'(boot_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_q <= boot_mode;
    else if (hit_i && mode_q == MODE_ASSUME)
      mode_q <= verdict_i;
  end

  assign mode_o = mode_q;

  a_r1_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'd3);

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_ASSUME) |=> $stable(mode_q));
endmodule

// File: rtl/irq_swizzle.sv
module irq_swizzle
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned LVL_W    = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic [LVL_W-1:0]     lvl_i,
  input  route_mode_e          mode_i,
  input  logic                 alt_board_i,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  logic [LINE_W-1:0] rot;
  assign rot = alt_board_i ? LINE_W'(3) : LINE_W'(2);

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < PINS_PER_SLOT; p++) begin
        logic [LINE_W-1:0] tgt;
        if (mode_i == MODE_BROKEN) tgt = LINE_W'(p);
        else                       tgt = LINE_W'(s) + LINE_W'(p) + rot;
        if (lvl_i[s*PINS_PER_SLOT+p]) irq_o[tgt] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_route_detect.sv
module irq_route_detect
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = 24,
  parameter logic [7:0]  LINE_OFS  = 8'h3C,
  parameter int unsigned BASE_IRQ  = 27,
  parameter int unsigned HIGH_OFS  = 64,
  localparam int unsigned LVL_W    = NUM_SLOTS * PINS_PER_SLOT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              alt_board_i,
  input  logic [1:0]        boot_mode_i,
  input  logic [LVL_W-1:0]  pin_lvl_i,
  output logic [1:0]        mode_o,
  output logic [3:0]        irq_o
);
  logic        hit;
  route_mode_e verdict, mode;

  irq_write_classifier #(
    .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .BASE_IRQ(BASE_IRQ), .HIGH_OFS(HIGH_OFS)
  ) i_classifier (
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_wdata_i),
    .alt_board_i(alt_board_i), .hit_o(hit), .verdict_o(verdict)
  );

  irq_mode_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .boot_mode_i(boot_mode_i),
    .hit_i(hit), .verdict_i(verdict), .mode_o(mode)
  );

  irq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) i_swizzle (
    .lvl_i(pin_lvl_i), .mode_i(mode), .alt_board_i(alt_board_i), .irq_o(irq_o)
  );

  assign mode_o = mode;

  // checks across the block boundary
  logic [7:0] slot_lo, slot_hi;
  assign slot_lo = 8'(BASE_IRQ) + {6'b0, cfg_addr_i[12:11]};
  assign slot_hi = slot_lo + 8'(HIGH_OFS);

  a_r3_alt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_board_i |=> $stable(mode_o));

  a_r6_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i[7:0] == LINE_OFS && !alt_board_i && mode_o == 2'd0 &&
     cfg_wdata_i != 8'(BASE_IRQ) && cfg_wdata_i != slot_lo && cfg_wdata_i != slot_hi)
    |=> mode_o == 2'd2);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_lvl_i == '0) |-> (irq_o == 4'b0));

  a_r10_no_excess: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(pin_lvl_i));
endmodule

// File: tb/test_irq_route_detect.sv
module test_irq_route_detect;
  localparam int NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [23:0] cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        alt_board_i = 1'b0;
  logic [1:0]  boot_mode_i = '0;
  logic [NS*4-1:0] pin_lvl_i = '0;
  logic [1:0]  mode_o;
  logic [3:0]  irq_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  irq_route_detect #(.NUM_SLOTS(NS)) i_irq_route_detect (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .alt_board_i, .boot_mode_i, .pin_lvl_i, .mode_o, .irq_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq(int md, bit alt, logic [NS*4-1:0] lv);
    logic [3:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (lv[s*4+p]) r[(md == 1) ? p : (s + p + (alt ? 3 : 2)) % 4] = 1'b1;
    return r;
  endfunction

  task automatic do_reset(logic [1:0] bm, logic [1:0] exp);
    @(negedge clk_i);
    boot_mode_i = bm;
    #1 rst_ni = 1'b0;
    #1 chk("R1 reset mode", mode_o, exp);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 mode after release", mode_o, exp);
  endtask

  task automatic cfg_write(int slot, logic [7:0] ofs, logic [7:0] val, bit we = 1'b1);
    @(negedge clk_i);
    cfg_we_i = we;
    cfg_addr_i = {8'h00, 5'(slot), 3'b000, ofs};
    cfg_wdata_i = val;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset_modes();
    do_reset(2'd0, 2'd0);
    do_reset(2'd1, 2'd1);
    do_reset(2'd2, 2'd2);
    do_reset(2'd3, 2'd0);
  endtask

  task automatic t_value27();
    do_reset(2'd0, 2'd0);
    cfg_write(2, 8'h3C, 8'd27);
    chk("R4 27 on slot%4==2 keeps assume", mode_o, 2'd0);
    cfg_write(10, 8'h3C, 8'd27);
    chk("R4 27 on slot 10 keeps assume", mode_o, 2'd0);
    // R11: mode must not move before the sampling edge
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = {8'h00, 5'd1, 3'b000, 8'h3C}; cfg_wdata_i = 8'd27;
    #2 chk("R11 mode unchanged before edge", mode_o, 2'd0);
    @(posedge clk_i); #1;
    chk("R11 mode moves at edge", mode_o, 2'd1);
    @(negedge clk_i); cfg_we_i = 1'b0;
    chk("R4 27 on slot 1 gives broken", mode_o, 2'd1);
    cfg_write(3, 8'h3C, 8'd99);
    chk("R2 broken sticks", mode_o, 2'd1);
  endtask

  task automatic t_filters();
    do_reset(2'd0, 2'd0);
    cfg_write(1, 8'h3D, 8'd5);
    chk("R3 wrong offset ignored", mode_o, 2'd0);
    cfg_write(1, 8'h3C, 8'd5, 1'b0);
    chk("R3 strobe low ignored", mode_o, 2'd0);
    alt_board_i = 1'b1;
    cfg_write(1, 8'h3C, 8'd5);
    chk("R3 alt board ignored", mode_o, 2'd0);
    alt_board_i = 1'b0;
    cfg_write(5, 8'h3C, 8'd28);
    chk("R5 27+s on slot 5 gives broken", mode_o, 2'd1);
    do_reset(2'd0, 2'd0);
    cfg_write(6, 8'h3C, 8'd93);
    chk("R5 91+s on slot 6 gives broken", mode_o, 2'd1);
    do_reset(2'd0, 2'd0);
    cfg_write(0, 8'h3C, 8'd91);
    chk("R5 91 on slot 0 gives broken", mode_o, 2'd1);
  endtask

  task automatic t_force();
    do_reset(2'd0, 2'd0);
    cfg_write(3, 8'h3C, 8'd29);
    chk("R6 mismatched value gives force", mode_o, 2'd2);
    cfg_write(1, 8'h3C, 8'd27);
    chk("R2 force sticks", mode_o, 2'd2);
    do_reset(2'd0, 2'd0);
    cfg_write(0, 8'h3C, 8'd40);
    chk("R6 value 40 gives force", mode_o, 2'd2);
  endtask

  task automatic route_sweep(string req, int md, bit alt);
    alt_board_i = alt;
    for (int b = 0; b < NS*4; b++) begin
      @(negedge clk_i);
      pin_lvl_i = '0; pin_lvl_i[b] = 1'b1;
      #1 chk(req, irq_o, exp_irq(md, alt, pin_lvl_i));
    end
    @(negedge clk_i); pin_lvl_i = '0;
    #1 chk("R10 all low", irq_o, 4'h0);
    alt_board_i = 1'b0;
  endtask

  task automatic t_routing();
    do_reset(2'd2, 2'd2);
    route_sweep("R8 swizzle +2", 2, 1'b0);
    route_sweep("R9 swizzle +3", 2, 1'b1);
    do_reset(2'd0, 2'd0);
    route_sweep("R8 assume-ok swizzle +2", 0, 1'b0);
    do_reset(2'd1, 2'd1);
    route_sweep("R7 pass-through", 1, 1'b0);
    route_sweep("R7 pass-through alt", 1, 1'b1);
  endtask

  task automatic t_or();
    logic [NS*4-1:0] pats [4] = '{32'h0000_0011, 32'h8000_0001, 32'h0F00_0000, 32'h1248_1248};
    for (int m = 0; m < 3; m++) begin
      do_reset(2'(m), 2'(m));
      foreach (pats[i]) begin
        @(negedge clk_i); pin_lvl_i = pats[i];
        #1 chk("R10 OR of sources", irq_o, exp_irq(m, 1'b0, pats[i]));
      end
      @(negedge clk_i); pin_lvl_i = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_modes();
    t_value27();
    t_filters();
    t_force();
    t_routing();
    t_or();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule